// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the target side of a two-wire serial memory. The bus clock and data lines arrive as plain inputs and are sampled by the system clock. The only output is an open-drain enable that pulls the data line low. The controller finds bus start and stop events and checks the device-select byte against a three-bit strap. It collects a word address from two further bytes. It then either buffers incoming data bytes or streams data bytes back to the host, and it acknowledges each byte it accepts.

Data bytes of a write are staged in a page buffer. They reach the memory array only when a stop ends the transfer. The stop starts a self-timed write cycle whose length is a parameter counted in system clocks. During that cycle the controller ignores the bus, so it does not acknowledge its own address. A host finds out that the cycle is over by sending the address again until it is acknowledged. The array is a synchronous RAM inside the block. A lock input stops any data from being committed.

Top module: `tw_eeprom_target`

## Requirements
- R1: A start is a high-to-low data transition while the bus clock is high; a stop is a low-to-high data transition while the bus clock is high. A start at any point, including inside a byte, drops the partial byte and makes the next eight clocks a fresh select byte.
- R2: The select byte is sent MSB first: bits 7..4 must be 1010, bits 3..1 must equal the strap input, and bit 0 selects read (1) or write (0). On a match the target holds data low through the ninth clock.
- R3: A select byte that does not match is not acknowledged (the line stays high on the ninth clock), and the target ignores the bus until the next start.
- R4: A write transfer sends two address bytes after the select byte. The word address is bits 6..0 of the first byte followed by all eight bits of the second; bit 7 of the first byte is ignored and the array uses the low MEM_AW bits. Both bytes are acknowledged.
- R5: Each data byte of a write is acknowledged, and the low log2(PAGE_BYTES) address bits then advance; they wrap from the last byte of a page to the first byte of the same page.
- R6: Buffered data is written to the array only when a stop ends a write transfer. A transfer ended by a repeated start writes nothing and starts no write cycle.
- R7: A stop that commits at least one byte starts a busy period of WR_CYCLES system clocks. During that period the select byte is not acknowledged. The first select byte sent after the period ends is acknowledged.
- R8: In a read, each byte goes out MSB first, and the data line changes only after the bus clock falls. A host acknowledge on the ninth clock makes the target send the byte at the next address, wrapping from the top of the array to address 0. A host non-acknowledge ends the read.
- R9: A read that is not preceded by an address phase starts at the address after the last byte written or read.
- R10: While the lock input is high, data bytes are still acknowledged but nothing reaches the array and no busy period starts.
- R11: After reset the data line is released, and the target changes its drive only while the sampled bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Two-wire bus clock level |
| bus_dat_i | input | 1 | Two-wire bus data level (resolved line) |
| dev_sel_i | input | 3 | Strap value compared with select byte bits 3..1 |
| wr_lock_i | input | 1 | High blocks all array writes |
| bus_dat_low_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The embedded assertions check several rules on every cycle. Drive changes happen only while the clock is low. A rising drive outside a read happens only in the ninth-clock slot. A start always resynchronises the byte framing, and page writes never move the page bits. Array writes happen only inside a busy period, a busy period begins only from a commit request, and the line is released throughout that period. The values themselves can only be shown by the bench's bus scenarios: which bytes land where after a page wrap, that an aborted or locked write leaves old data in place, how the read pointer carries over between transfers and across the end of the array, and that polling is refused and then accepted again.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } tw_phase_e;

  localparam logic [3:0] TW_FAMILY = 4'b1010;
endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  output logic bclk_lvl,
  output logic bdat_lvl,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] clk_sy, dat_sy;
  logic       clk_q, dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sy <= 2'b11;
      dat_sy <= 2'b11;
      clk_q  <= 1'b1;
      dat_q  <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[0], bus_clk_i};
      dat_sy <= {dat_sy[0], bus_dat_i};
      clk_q  <= clk_sy[1];
      dat_q  <= dat_sy[1];
    end
  end

  assign bclk_lvl  = clk_sy[1];
  assign bdat_lvl  = dat_sy[1];
  assign bclk_rise = clk_sy[1] & ~clk_q;
  assign bclk_fall = ~clk_sy[1] & clk_q;
  // events qualified by the clock being high on both samples
  assign start_det = clk_sy[1] & clk_q & dat_q & ~dat_sy[1];
  assign stop_det  = clk_sy[1] & clk_q & ~dat_q & dat_sy[1];
endmodule

// File: rtl/tw_target_fsm.sv
module tw_target_fsm
  import tw_pkg::*;
#(
  parameter int MEM_AW = 12,
  parameter int PG_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_lvl,
  input  logic              bdat_lvl,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel,
  input  logic              wr_lock,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic [MEM_AW-1:0] ptr,
  output logic              pb_we,
  output logic              pb_clr,
  output logic [PG_W-1:0]   pb_idx,
  output logic [7:0]        pb_data,
  output logic              commit_go,
  output logic              dat_low
);
  tw_phase_e  phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic [6:0] ahi;
  logic       in_ack;
  logic       host_more;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      ahi       <= '0;
      in_ack    <= 1'b0;
      host_more <= 1'b0;
      ptr       <= '0;
      pb_we     <= 1'b0;
      pb_clr    <= 1'b0;
      pb_idx    <= '0;
      pb_data   <= '0;
      commit_go <= 1'b0;
      dat_low   <= 1'b0;
    end else begin
      pb_we     <= 1'b0;
      pb_clr    <= 1'b0;
      commit_go <= 1'b0;
      if (busy) begin
        phase   <= PH_IDLE;
        in_ack  <= 1'b0;
        bitcnt  <= '0;
        dat_low <= 1'b0;
      end else if (stop_det) begin
        if (phase == PH_WR) commit_go <= 1'b1;
        phase   <= PH_IDLE;
        in_ack  <= 1'b0;
        bitcnt  <= '0;
        dat_low <= 1'b0;
      end else if (start_det) begin
        phase   <= PH_DEV;
        in_ack  <= 1'b0;
        bitcnt  <= '0;
        dat_low <= 1'b0;
      end else begin
        case (phase)
          PH_DEV, PH_AHI, PH_ALO, PH_WR: begin
            if (bclk_rise && !in_ack && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], bdat_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (bclk_fall && in_ack) begin
              // end of the acknowledge slot
              in_ack  <= 1'b0;
              dat_low <= 1'b0;
              bitcnt  <= '0;
              case (phase)
                PH_DEV: begin
                  if (shreg[0]) begin
                    phase   <= PH_RD;
                    txreg   <= rd_data;
                    dat_low <= ~rd_data[7];
                    ptr     <= ptr + MEM_AW'(1);
                  end else begin
                    phase <= PH_AHI;
                  end
                end
                PH_AHI:  phase <= PH_ALO;
                default: phase <= PH_WR;
              endcase
            end else if (bclk_fall && !in_ack && bitcnt == 4'd8) begin
              // byte complete: decide and open the acknowledge slot
              case (phase)
                PH_DEV: begin
                  if (shreg[7:4] == TW_FAMILY && shreg[3:1] == dev_sel) begin
                    in_ack  <= 1'b1;
                    dat_low <= 1'b1;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                PH_AHI: begin
                  ahi     <= shreg[6:0];
                  in_ack  <= 1'b1;
                  dat_low <= 1'b1;
                end
                PH_ALO: begin
                  ptr     <= MEM_AW'({ahi, shreg});
                  pb_clr  <= 1'b1;
                  in_ack  <= 1'b1;
                  dat_low <= 1'b1;
                end
                default: begin
                  pb_idx            <= ptr[PG_W-1:0];
                  pb_data           <= shreg;
                  pb_we             <= ~wr_lock;
                  ptr[PG_W-1:0]     <= ptr[PG_W-1:0] + PG_W'(1);
                  in_ack            <= 1'b1;
                  dat_low           <= 1'b1;
                end
              endcase
            end
          end
          PH_RD: begin
            if (bclk_rise) begin
              if (bitcnt == 4'd8) host_more <= ~bdat_lvl;
              bitcnt <= bitcnt + 4'd1;
            end else if (bclk_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                txreg   <= {txreg[6:0], 1'b0};
                dat_low <= ~txreg[6];
              end else if (bitcnt == 4'd8) begin
                dat_low <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                if (host_more) begin
                  txreg   <= rd_data;
                  dat_low <= ~rd_data[7];
                  ptr     <= ptr + MEM_AW'(1);
                  bitcnt  <= '0;
                end else begin
                  phase <= PH_IDLE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: drive changes only follow a sampled low bus clock
  a_r11_drive_while_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(start_det) && !$past(stop_det) && dat_low != $past(dat_low)) |-> !$past(bclk_lvl));

  // R2: outside reads, the drive rises only to open the ninth-clock slot
  a_r2_ack_slot: assert property (@(posedge clk) disable iff (rst)
    ($rose(dat_low) && phase != PH_RD) |-> $past(bitcnt) == 4'd8);

  // R1: a start always resynchronises byte framing
  a_r1_start_resync: assert property (@(posedge clk) disable iff (rst)
    $past(start_det && !busy && !stop_det) |-> (phase == PH_DEV && bitcnt == 4'd0));

  // R5: data bytes never move the page bits of the pointer
  a_r5_page_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WR && $past(phase) == PH_WR) |-> ptr[MEM_AW-1:PG_W] == $past(ptr[MEM_AW-1:PG_W]));
endmodule

// File: rtl/tw_write_engine.sv
module tw_write_engine #(
  parameter int MEM_AW    = 12,
  parameter int PG_W      = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pb_we,
  input  logic                   pb_clr,
  input  logic [PG_W-1:0]        pb_idx,
  input  logic [7:0]             pb_data,
  input  logic                   commit_go,
  input  logic [MEM_AW-PG_W-1:0] page_base,
  output logic                   busy,
  output logic                   mem_we,
  output logic [MEM_AW-1:0]      mem_addr,
  output logic [7:0]             mem_wdata
);
  localparam int PAGE = 1 << PG_W;
  localparam int CW   = $clog2(WR_CYCLES + 1);
  localparam int BW   = MEM_AW - PG_W;

  logic [7:0]      pbuf [PAGE];
  logic [7:0]      buf_q;
  logic [PAGE-1:0] valid;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   base;
  logic [PG_W-1:0] idx_q;
  logic            we_q;

  // staging buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pb_idx] <= pb_data;
    buf_q <= pbuf[cnt[PG_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
      base  <= '0;
      idx_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (busy) begin
        we_q  <= (32'(cnt) < 32'(PAGE)) && valid[cnt[PG_W-1:0]];
        idx_q <= cnt[PG_W-1:0];
        cnt   <= cnt + CW'(1);
        if (cnt == CW'(WR_CYCLES - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else begin
        if (pb_clr)     valid         <= '0;
        else if (pb_we) valid[pb_idx] <= 1'b1;
        if (commit_go && |valid) begin
          busy <= 1'b1;
          cnt  <= '0;
          base <= page_base;
        end
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = {base, idx_q};
  assign mem_wdata = buf_q;

  // R6: the array is written only inside a busy period
  a_r6_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R7: a busy period is only opened by a commit request
  a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit_go));
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target #(
  parameter int MEM_AW     = 12,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_clk_i,
  input  logic       bus_dat_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wr_lock_i,
  output logic       bus_dat_low_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic              bclk_lvl, bdat_lvl, bclk_rise, bclk_fall, start_det, stop_det;
  logic [MEM_AW-1:0] ptr;
  logic              pb_we, pb_clr, commit_go, busy;
  logic [PG_W-1:0]   pb_idx;
  logic [7:0]        pb_data, rd_data, mem_wdata;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;

  tw_bus_sense u_sense (
    .clk       (clk),
    .rst       (rst),
    .bus_clk_i (bus_clk_i),
    .bus_dat_i (bus_dat_i),
    .bclk_lvl  (bclk_lvl),
    .bdat_lvl  (bdat_lvl),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tw_target_fsm #(.MEM_AW(MEM_AW), .PG_W(PG_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bclk_lvl  (bclk_lvl),
    .bdat_lvl  (bdat_lvl),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_sel   (dev_sel_i),
    .wr_lock   (wr_lock_i),
    .busy      (busy),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .pb_we     (pb_we),
    .pb_clr    (pb_clr),
    .pb_idx    (pb_idx),
    .pb_data   (pb_data),
    .commit_go (commit_go),
    .dat_low   (bus_dat_low_o)
  );

  tw_write_engine #(.MEM_AW(MEM_AW), .PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .pb_we     (pb_we),
    .pb_clr    (pb_clr),
    .pb_idx    (pb_idx),
    .pb_data   (pb_data),
    .commit_go (commit_go),
    .page_base (ptr[MEM_AW-1:PG_W]),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  tw_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

  // R7: the line stays released for the whole busy period
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !bus_dat_low_o);
endmodule

// File: tb/tw_eeprom_target_tb.sv
`timescale 1ns/1ps
module tw_eeprom_target_tb;
  localparam int QTR = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic lock = 1'b0;
  logic [2:0] sel = 3'b101;
  logic dat_low;
  wire  line = sda_m & ~dat_low;

  int checks = 0;
  int fails  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    obs_q[$];

  always #10 clk = ~clk;

  tw_eeprom_target #(.MEM_AW(12), .PAGE_BYTES(64), .WR_CYCLES(600)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .bus_clk_i     (scl_m),
    .bus_dat_i     (line),
    .dev_sel_i     (sel),
    .wr_lock_i     (lock),
    .bus_dat_low_o (dat_low)
  );

  // monitor: pairs each observed bus result with its expected item
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      int o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (o != e) begin
        fails++;
        $display("FAIL %s: actual %0h expected %0h", t, o, e);
      end
    end
  end

  task automatic quarter();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; quarter(); scl_m = 1'b1; quarter(); quarter(); scl_m = 1'b0; quarter();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter(); b = line; quarter(); scl_m = 1'b0; quarter();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b0; quarter(); scl_m = 1'b0; quarter();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b1; quarter();
  endtask

  task automatic send_byte(input logic [7:0] v, input int exp_ack, input string tag);
    logic a;
    exp_q.push_back(exp_ack); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a);
    obs_q.push_back(int'(a));
  endtask

  task automatic recv_byte(input logic host_nack, input int exp_v, input string tag);
    logic [7:0] v;
    logic b;
    exp_q.push_back(exp_v); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(host_nack);
    obs_q.push_back(int'(v));
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bus_start();
    send_byte(dev(1'b0), 0, tag);
    send_byte(hi, 0, tag);
    send_byte(lo, 0, tag);
  endtask

  task automatic rand_read_start(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    addr_phase(hi, lo, tag);
    bus_start();
    send_byte(dev(1'b1), 0, tag);
  endtask

  task automatic poll(output logic a);
    bus_start();
    for (int i = 7; i >= 0; i--) wbit(dev(1'b0)[i]);
    rbit(a);
    bus_stop();
  endtask

  task automatic wait_cycle();
    repeat (700) @(negedge clk);
  endtask

  task automatic direct_check(input logic ok, input int act, input int expv, input string tag);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    int tries;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R11: line released after reset
    direct_check(dat_low == 1'b0, int'(dat_low), 0, "R11 reset drive");

    // R3: wrong strap, wrong family code
    bus_start();
    send_byte({4'b1010, sel ^ 3'b001, 1'b0}, 1, "R3 strap mismatch nack");
    bus_stop();
    bus_start();
    send_byte({4'b1011, sel, 1'b0}, 1, "R3 family mismatch nack");
    bus_stop();
    // R2: matching select byte is acknowledged
    bus_start();
    send_byte(dev(1'b0), 0, "R2 select ack");
    bus_stop();

    // R4/R5: page write at 0x100 with ignored top bit set
    addr_phase(8'h81, 8'h00, "R4 address ack");
    send_byte(8'hAA, 0, "R5 data ack");
    send_byte(8'h55, 0, "R5 data ack");
    send_byte(8'h3C, 0, "R5 data ack");
    send_byte(8'hC3, 0, "R5 data ack");
    bus_stop();
    // R7: polling refused at first, then accepted
    poll(a);
    direct_check(a == 1'b1, int'(a), 1, "R7 nack while busy");
    tries = 0;
    while (a == 1'b1 && tries < 6) begin poll(a); tries++; end
    direct_check(a == 1'b0, int'(a), 0, "R7 ack after write cycle");

    // R6/R8: sequential read of the committed page data
    rand_read_start(8'h01, 8'h00, "R8 read select ack");
    recv_byte(1'b0, 8'hAA, "R6 committed byte 0");
    recv_byte(1'b0, 8'h55, "R8 sequential byte 1");
    recv_byte(1'b0, 8'h3C, "R8 sequential byte 2");
    recv_byte(1'b1, 8'hC3, "R8 sequential byte 3");
    bus_stop();

    // R5: wrap inside the page (0x13F then 0x100)
    addr_phase(8'h01, 8'h3F, "R5 address ack");
    send_byte(8'h11, 0, "R5 data ack");
    send_byte(8'h22, 0, "R5 data ack");
    bus_stop();
    wait_cycle();
    rand_read_start(8'h01, 8'h3F, "R5 read select ack");
    recv_byte(1'b1, 8'h11, "R5 last byte of page");
    bus_stop();
    rand_read_start(8'h01, 8'h00, "R5 read select ack");
    recv_byte(1'b0, 8'h22, "R5 wrapped to page start");
    recv_byte(1'b1, 8'h55, "R8 next byte after ack");
    bus_stop();
    // R9: current-address read continues at 0x102
    bus_start();
    send_byte(dev(1'b1), 0, "R9 select ack");
    recv_byte(1'b1, 8'h3C, "R9 current address byte");
    bus_stop();

    // R1/R6: abort a write with a start inside a byte
    addr_phase(8'h01, 8'h01, "R6 address ack");
    send_byte(8'h99, 0, "R6 data ack");
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_start();
    send_byte(dev(1'b1), 0, "R1 resync select ack");
    recv_byte(1'b1, 8'h3C, "R1 read after abort");
    bus_stop();
    poll(a);
    direct_check(a == 1'b0, int'(a), 0, "R6 no write cycle after abort");
    rand_read_start(8'h01, 8'h01, "R6 read select ack");
    recv_byte(1'b1, 8'h55, "R6 aborted byte not stored");
    bus_stop();

    // R10: locked write acknowledged but not stored
    lock = 1'b1;
    addr_phase(8'h01, 8'h02, "R10 address ack");
    send_byte(8'hEE, 0, "R10 locked data ack");
    bus_stop();
    lock = 1'b0;
    poll(a);
    direct_check(a == 1'b0, int'(a), 0, "R10 no write cycle when locked");
    rand_read_start(8'h01, 8'h02, "R10 read select ack");
    recv_byte(1'b1, 8'h3C, "R10 old data kept");
    bus_stop();

    // R8: read wraps from the top of the array to address 0
    addr_phase(8'h0F, 8'hFF, "R8 address ack");
    send_byte(8'h5A, 0, "R8 data ack");
    bus_stop();
    wait_cycle();
    addr_phase(8'h00, 8'h00, "R8 address ack");
    send_byte(8'hA5, 0, "R8 data ack");
    bus_stop();
    wait_cycle();
    rand_read_start(8'h0F, 8'hFF, "R8 read select ack");
    recv_byte(1'b0, 8'h5A, "R8 top of array");
    recv_byte(1'b1, 8'hA5, "R8 wrapped to address 0");
    bus_stop();

    repeat (5) @(negedge clk);
    direct_check(exp_q.size() == 0, exp_q.size(), 0, "R8 scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule